// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the memory traffic of a software interrupt and of the matching return for a 16-bit processor model with segmented addressing. A physical address is the segment shifted left by four bits plus the offset, kept to 20 bits. The block holds the instruction pointer, code segment, flags and stack pointer. The stack segment comes in as an input.

When an interrupt request is taken, the block saves the machine state on a stack that grows downward. It then fetches the handler's instruction pointer and code segment from a table of 4-byte entries that starts at physical address zero. When a return request is taken, it restores the three saved words from the stack.

A divide error enters through table entry zero. A load port lets the rest of the processor set the four registers while the sequencer is idle. Memory is reached through a word-wide request/acknowledge port that may stall for any number of cycles.

Top module: `intr_seq`

## Requirements
- R1: After reset, busy and mem_req are low, and ip, cs, flags and sp all read 0.
- R2: Entry makes three writes in this order: flags, then cs, then ip. Before each write the stack pointer drops by 2 (mod 2^16), and the word goes to physical address ss*16 + sp. After entry, sp is 6 lower than before.
- R3: Once mem_req is high, mem_addr, mem_we and mem_wdata stay unchanged until the cycle in which mem_ack is sampled high. Each transfer completes on that edge.
- R4: For vector n, entry reads the word at physical 4n and then the word at 4n+2. For vector 21h these are 84h and 86h.
- R5: The word read from 4n becomes ip and the word read from 4n+2 becomes cs.
- R6: A high div_err starts entry with vector 0 and overrides int_req/int_vec in the same cycle.
- R7: Return makes three reads in this order: ip, then cs, then flags. Each read is at ss*16 + sp, and sp rises by 2 after each read. After return, sp is 6 higher and the three registers hold the words read.
- R8: busy goes high in the cycle after an accepted request. It stays high until the last transfer completes: cs loaded on entry, flags loaded on return. Requests that arrive while busy are ignored.
- R9: Stack offsets wrap modulo 2^16 and physical addresses wrap modulo 2^20.
- R10: While idle, a high st_load writes st_ip, st_cs, st_flags and st_sp into the registers. While busy, st_load is ignored.
- R11: If an interrupt request (int_req or div_err) and iret_req arrive in the same idle cycle, entry is performed and the return request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 1 | Software interrupt request |
| int_vec | input | 8 | Vector number for int_req |
| div_err | input | 1 | Divide error, enters through vector 0 |
| iret_req | input | 1 | Interrupt return request |
| st_load | input | 1 | Register load strobe (idle only) |
| st_ip | input | 16 | Instruction pointer load value |
| st_cs | input | 16 | Code segment load value |
| st_flags | input | 16 | Flags load value |
| st_sp | input | 16 | Stack pointer load value |
| ss | input | 16 | Stack segment |
| busy | output | 1 | Sequence in progress |
| ip | output | 16 | Instruction pointer |
| cs | output | 16 | Code segment |
| flags | output | 16 | Flags |
| sp | output | 16 | Stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes on this cycle's edge |

## Verification
The hardest cases to reach from the ports are stack offsets and segments near the top of their ranges. In those cases a push or pop crosses zero and a physical address passes 2^20. Directed cases cover both. One places sp at 0 so the pushes land at FFFEh and below. Another uses ss = FFFFh with a small sp, so the pushes straddle the 20-bit wrap at physical zero. Around these sit seeded random rounds of entry followed by return. The memory model inserts random wait states in those rounds, and extra requests and loads are injected while the sequencer is busy.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_PSH_FL = 4'd1,
    S_PSH_CS = 4'd2,
    S_PSH_IP = 4'd3,
    S_VEC_IP = 4'd4,
    S_VEC_CS = 4'd5,
    S_POP_IP = 4'd6,
    S_POP_CS = 4'd7,
    S_POP_FL = 4'd8
  } seq_st_e;

  function automatic logic st_is_push(input seq_st_e s);
    return (s == S_PSH_FL) || (s == S_PSH_CS) || (s == S_PSH_IP);
  endfunction

  function automatic logic st_is_pop(input seq_st_e s);
    return (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_FL);
  endfunction

  function automatic logic st_is_vec(input seq_st_e s);
    return (s == S_VEC_IP) || (s == S_VEC_CS);
  endfunction

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_req,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             div_err,
  input  logic             iret_req,
  input  logic             xfer,
  output seq_st_e          st,
  output logic [VEC_W-1:0] vec,
  output logic             busy
);

  seq_st_e          st_q, st_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;
  logic             idle;

  assign idle = (st_q == S_IDLE);

  // next state: entry outranks return, divide error outranks int_req
  always_comb begin
    st_d   = st_q;
    vec_d  = vec_q;
    vec_en = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (div_err) begin
          st_d   = S_PSH_FL;
          vec_d  = '0;
          vec_en = 1'b1;
        end else if (int_req) begin
          st_d   = S_PSH_FL;
          vec_d  = int_vec;
          vec_en = 1'b1;
        end else if (iret_req) begin
          st_d = S_POP_IP;
        end
      end
      S_PSH_FL: if (xfer) st_d = S_PSH_CS;
      S_PSH_CS: if (xfer) st_d = S_PSH_IP;
      S_PSH_IP: if (xfer) st_d = S_VEC_IP;
      S_VEC_IP: if (xfer) st_d = S_VEC_CS;
      S_VEC_CS: if (xfer) st_d = S_IDLE;
      S_POP_IP: if (xfer) st_d = S_POP_CS;
      S_POP_CS: if (xfer) st_d = S_POP_FL;
      S_POP_FL: if (xfer) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_en && idle) begin
      vec_q <= vec_d;
    end
  end

  assign st   = st_q;
  assign vec  = vec_q;
  assign busy = !idle;

endmodule

// File: rtl/intr_seq_agu.sv
module intr_seq_agu
  import intr_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 8,
  parameter int SEG_SHIFT = 4
) (
  input  seq_st_e                      st,
  input  logic [VEC_W-1:0]             vec,
  input  logic [DATA_W-1:0]            ss,
  input  logic [DATA_W-1:0]            sp,
  input  logic [DATA_W-1:0]            ip,
  input  logic [DATA_W-1:0]            cs,
  input  logic [DATA_W-1:0]            flags,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [DATA_W+SEG_SHIFT-1:0]  mem_addr,
  output logic [DATA_W-1:0]            mem_wdata
);

  localparam int                ADDR_W  = DATA_W + SEG_SHIFT;
  localparam int                PAD_W   = DATA_W - VEC_W - 2;
  localparam logic [DATA_W-1:0] STEP    = DATA_W'(DATA_W / 8);

  logic [DATA_W-1:0] seg;
  logic [DATA_W-1:0] off;
  logic [DATA_W-1:0] tbl_off;

  // table entry of 4 bytes per vector, second word one step above
  assign tbl_off = {{PAD_W{1'b0}}, vec, 2'b00};

  always_comb begin
    seg       = ss;
    off       = sp;
    mem_wdata = '0;
    case (st)
      S_PSH_FL: begin off = sp - STEP; mem_wdata = flags; end
      S_PSH_CS: begin off = sp - STEP; mem_wdata = cs;    end
      S_PSH_IP: begin off = sp - STEP; mem_wdata = ip;    end
      S_VEC_IP: begin seg = '0; off = tbl_off;            end
      S_VEC_CS: begin seg = '0; off = tbl_off + STEP;     end
      default:  begin seg = ss; off = sp;                 end
    endcase
  end

  assign mem_req  = (st != S_IDLE);
  assign mem_we   = st_is_push(st);
  assign mem_addr = ADDR_W'({seg, {SEG_SHIFT{1'b0}}}) + ADDR_W'({{SEG_SHIFT{1'b0}}, off});

endmodule

// File: rtl/intr_seq_regs.sv
module intr_seq_regs
  import intr_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           st,
  input  logic              xfer,
  input  logic [DATA_W-1:0] rdata,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_ip,
  input  logic [DATA_W-1:0] ld_cs,
  input  logic [DATA_W-1:0] ld_flags,
  input  logic [DATA_W-1:0] ld_sp,
  output logic [DATA_W-1:0] ip,
  output logic [DATA_W-1:0] cs,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] sp
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  logic [DATA_W-1:0] ip_q, ip_d, cs_q, cs_d, fl_q, fl_d, sp_q, sp_d;
  logic              ip_en, cs_en, fl_en, sp_en;
  logic              ld_ok;

  assign ld_ok = ld && (st == S_IDLE);

  always_comb begin
    ip_d  = ip_q;  ip_en = 1'b0;
    cs_d  = cs_q;  cs_en = 1'b0;
    fl_d  = fl_q;  fl_en = 1'b0;
    sp_d  = sp_q;  sp_en = 1'b0;
    if (ld_ok) begin
      ip_d = ld_ip;    ip_en = 1'b1;
      cs_d = ld_cs;    cs_en = 1'b1;
      fl_d = ld_flags; fl_en = 1'b1;
      sp_d = ld_sp;    sp_en = 1'b1;
    end else if (xfer) begin
      if (st_is_push(st)) begin
        sp_d = sp_q - STEP; sp_en = 1'b1;
      end
      if (st_is_pop(st)) begin
        sp_d = sp_q + STEP; sp_en = 1'b1;
      end
      if (st == S_VEC_IP || st == S_POP_IP) begin
        ip_d = rdata; ip_en = 1'b1;
      end
      if (st == S_VEC_CS || st == S_POP_CS) begin
        cs_d = rdata; cs_en = 1'b1;
      end
      if (st == S_POP_FL) begin
        fl_d = rdata; fl_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= '0;
    else if (ip_en) ip_q <= ip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cs_q <= '0;
    else if (cs_en) cs_q <= cs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fl_q <= '0;
    else if (fl_en) fl_q <= fl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign ip    = ip_q;
  assign cs    = cs_q;
  assign flags = fl_q;
  assign sp    = sp_q;

endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int VEC_W     = 8,
  parameter  int SEG_SHIFT = 4,
  localparam int ADDR_W    = DATA_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_req,
  input  logic [VEC_W-1:0]  int_vec,
  input  logic              div_err,
  input  logic              iret_req,
  input  logic              st_load,
  input  logic [DATA_W-1:0] st_ip,
  input  logic [DATA_W-1:0] st_cs,
  input  logic [DATA_W-1:0] st_flags,
  input  logic [DATA_W-1:0] st_sp,
  input  logic [DATA_W-1:0] ss,
  output logic              busy,
  output logic [DATA_W-1:0] ip,
  output logic [DATA_W-1:0] cs,
  output logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  seq_st_e          st;
  logic [VEC_W-1:0] vec;
  logic             xfer;

  assign xfer = mem_req && mem_ack;

  intr_seq_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_req  (int_req),
    .int_vec  (int_vec),
    .div_err  (div_err),
    .iret_req (iret_req),
    .xfer     (xfer),
    .st       (st),
    .vec      (vec),
    .busy     (busy)
  );

  intr_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .xfer     (xfer),
    .rdata    (mem_rdata),
    .ld       (st_load),
    .ld_ip    (st_ip),
    .ld_cs    (st_cs),
    .ld_flags (st_flags),
    .ld_sp    (st_sp),
    .ip       (ip),
    .cs       (cs),
    .flags    (flags),
    .sp       (sp)
  );

  intr_seq_agu #(
    .DATA_W    (DATA_W),
    .VEC_W     (VEC_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_agu (
    .st        (st),
    .vec       (vec),
    .ss        (ss),
    .sp        (sp),
    .ip        (ip),
    .cs        (cs),
    .flags     (flags),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter  int DATA_W    = 16,
  parameter  int SEG_SHIFT = 4,
  localparam int ADDR_W    = DATA_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_req,
  input logic              div_err,
  input logic              iret_req,
  input logic              st_load,
  input logic              busy,
  input logic [DATA_W-1:0] ip,
  input logic [DATA_W-1:0] cs,
  input logic [DATA_W-1:0] flags,
  input logic [DATA_W-1:0] sp,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R3: request held steady until acknowledged
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2: each completed push lowers sp by one word
  p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_we) |=> (sp == $past(sp) - STEP));

  // R8: an accepted request raises busy on the next cycle
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (int_req || div_err || iret_req)) |=> busy);

  // R10: a load strobe while busy leaves every register alone
  p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_load && !(mem_req && mem_ack)) |=>
      ($stable(ip) && $stable(cs) && $stable(flags) && $stable(sp)));

endmodule

bind intr_seq intr_seq_chk #(.DATA_W(DATA_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_req   (int_req),
  .div_err   (div_err),
  .iret_req  (iret_req),
  .st_load   (st_load),
  .busy      (busy),
  .ip        (ip),
  .cs        (cs),
  .flags     (flags),
  .sp        (sp),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/intr_seq_tb.sv
module intr_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_req = 1'b0;
  logic [7:0]  int_vec = 8'h00;
  logic        div_err = 1'b0;
  logic        iret_req = 1'b0;
  logic        st_load = 1'b0;
  logic [15:0] st_ip = 16'h0, st_cs = 16'h0, st_flags = 16'h0, st_sp = 16'h0;
  logic [15:0] ss = 16'h0;
  logic        busy;
  logic [15:0] ip, cs, flags, sp;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic        mem_ack = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // model of the architectural state
  logic [15:0] m_ip, m_cs, m_fl, m_sp;

  // memory model and transfer log
  logic [15:0] mem [logic [19:0]];
  logic [19:0] wa [8];
  logic [15:0] wd [8];
  logic [19:0] ra [8];
  int          wn = 0, rn = 0;
  bit          pend = 0;
  logic [19:0] pa;
  logic        pw;
  logic [15:0] pd;
  int          wcnt = 0;

  always #2 clk = ~clk;

  intr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .int_vec(int_vec),
    .div_err(div_err), .iret_req(iret_req), .st_load(st_load),
    .st_ip(st_ip), .st_cs(st_cs), .st_flags(st_flags), .st_sp(st_sp),
    .ss(ss), .busy(busy), .ip(ip), .cs(cs), .flags(flags), .sp(sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ph(input logic [15:0] s, input logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  function automatic logic [15:0] mrd(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 16'h0;
  endfunction

  // memory responder: random wait states, logs each completed transfer
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      pend    = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      pend    = 0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1;
        pa   = mem_addr;
        pw   = mem_we;
        pd   = mem_wdata;
        wcnt = $urandom_range(0, 3);
      end
      if (wcnt == 0) begin
        chk("R3", "address held", {12'h0, mem_addr}, {12'h0, pa});
        chk("R3", "direction held", {31'h0, mem_we}, {31'h0, pw});
        if (pw) chk("R3", "wdata held", {16'h0, mem_wdata}, {16'h0, pd});
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          if (wn < 8) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
          wn++;
        end else begin
          mem_rdata = mrd(mem_addr);
          if (rn < 8) ra[rn] = mem_addr;
          rn++;
        end
      end else begin
        wcnt--;
      end
    end
  end

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk("R8", "sequence finished", {31'h0, busy}, 32'h0);
  endtask

  task automatic load_state(input logic [15:0] i, c, f, s);
    @(negedge clk);
    st_load = 1'b1; st_ip = i; st_cs = c; st_flags = f; st_sp = s;
    @(negedge clk);
    st_load = 1'b0;
    m_ip = i; m_cs = c; m_fl = f; m_sp = s;
    chk("R10", "ip loaded", {16'h0, ip}, {16'h0, i});
    chk("R10", "sp loaded", {16'h0, sp}, {16'h0, s});
  endtask

  task automatic check_regs(input string req);
    chk(req, "ip", {16'h0, ip}, {16'h0, m_ip});
    chk(req, "cs", {16'h0, cs}, {16'h0, m_cs});
    chk(req, "flags", {16'h0, flags}, {16'h0, m_fl});
    chk(req, "sp", {16'h0, sp}, {16'h0, m_sp});
  endtask

  // entry; a second request and a load strobe are injected while busy
  task automatic entry(input logic [7:0] vreq, input bit div, input bit with_iret);
    logic [7:0]  v;
    logic [15:0] tip, tcs;
    logic [19:0] ta;
    v   = div ? 8'h00 : vreq;
    tip = 16'($urandom);
    tcs = 16'($urandom);
    ta  = {10'h0, v, 2'b00};
    mem[ta]     = tip;
    mem[ta + 2] = tcs;
    @(negedge clk);
    wn = 0; rn = 0;
    int_req = 1'b1; int_vec = vreq; div_err = div; iret_req = with_iret;
    @(negedge clk);
    chk("R8", "busy after request", {31'h0, busy}, 32'h1);
    int_req = 1'b1; int_vec = 8'h33; div_err = 1'b0; iret_req = 1'b1;
    st_load = 1'b1; st_ip = 16'hDEAD; st_cs = 16'hBEEF; st_flags = 16'h5A5A; st_sp = 16'h0F00;
    @(negedge clk);
    int_req = 1'b0; iret_req = 1'b0; st_load = 1'b0;
    wait_idle();
    chk("R2", "write count", wn, 3);
    chk(with_iret ? "R11" : "R4", "read count", rn, 2);
    chk("R2", "flags push addr", {12'h0, wa[0]}, {12'h0, ph(ss, m_sp - 16'd2)});
    chk("R2", "flags push data", {16'h0, wd[0]}, {16'h0, m_fl});
    chk("R2", "cs push addr", {12'h0, wa[1]}, {12'h0, ph(ss, m_sp - 16'd4)});
    chk("R2", "cs push data", {16'h0, wd[1]}, {16'h0, m_cs});
    chk("R2", "ip push addr", {12'h0, wa[2]}, {12'h0, ph(ss, m_sp - 16'd6)});
    chk("R2", "ip push data", {16'h0, wd[2]}, {16'h0, m_ip});
    chk(div ? "R6" : "R4", "table ip addr", {12'h0, ra[0]}, {12'h0, ta});
    chk(div ? "R6" : "R4", "table cs addr", {12'h0, ra[1]}, {12'h0, ta + 20'd2});
    m_ip = tip; m_cs = tcs; m_sp = m_sp - 16'd6;
    check_regs("R5");
  endtask

  task automatic do_iret();
    logic [15:0] eip, ecs, efl;
    eip = mrd(ph(ss, m_sp));
    ecs = mrd(ph(ss, m_sp + 16'd2));
    efl = mrd(ph(ss, m_sp + 16'd4));
    @(negedge clk);
    wn = 0; rn = 0;
    iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    chk("R8", "busy after return request", {31'h0, busy}, 32'h1);
    wait_idle();
    chk("R7", "read count", rn, 3);
    chk("R7", "write count", wn, 0);
    chk("R7", "ip pop addr", {12'h0, ra[0]}, {12'h0, ph(ss, m_sp)});
    chk("R7", "cs pop addr", {12'h0, ra[1]}, {12'h0, ph(ss, m_sp + 16'd2)});
    chk("R7", "flags pop addr", {12'h0, ra[2]}, {12'h0, ph(ss, m_sp + 16'd4)});
    m_ip = eip; m_cs = ecs; m_fl = efl; m_sp = m_sp + 16'd6;
    check_regs("R7");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] o_ip, o_cs, o_fl, o_sp;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", {31'h0, busy}, 32'h0);
    chk("R1", "mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1", "ip", {16'h0, ip}, 32'h0);
    chk("R1", "cs", {16'h0, cs}, 32'h0);
    chk("R1", "flags", {16'h0, flags}, 32'h0);
    chk("R1", "sp", {16'h0, sp}, 32'h0);
    rst_n = 1'b1;

    // R4: vector 21h reads bytes 84h and 86h
    ss = 16'h3000;
    load_state(16'h1234, 16'h5678, 16'h0246, 16'h0100);
    entry(8'h21, 1'b0, 1'b0);
    chk("R4", "vector 21h ip word", {12'h0, ra[0]}, 32'h84);
    chk("R4", "vector 21h cs word", {12'h0, ra[1]}, 32'h86);
    do_iret();
    chk("R7", "round trip ip", {16'h0, ip}, 32'h1234);
    chk("R7", "round trip sp", {16'h0, sp}, 32'h0100);

    // R6: divide error beats int_req and uses vector 0
    entry(8'h05, 1'b1, 1'b0);
    do_iret();

    // R11: entry wins over a simultaneous return
    entry(8'h7E, 1'b0, 1'b1);
    do_iret();

    // R9: stack offset wraps below zero
    ss = 16'h2000;
    load_state(16'hA001, 16'hB002, 16'h0C03, 16'h0000);
    entry(8'hFF, 1'b0, 1'b0);
    chk("R9", "sp after wrap", {16'h0, sp}, 32'hFFFA);
    do_iret();
    chk("R9", "sp back to zero", {16'h0, sp}, 32'h0000);

    // R9: physical address wraps past 2^20
    ss = 16'hFFFF;
    load_state(16'h1111, 16'h2222, 16'h3333, 16'h0014);
    entry(8'h40, 1'b0, 1'b0);
    chk("R9", "flags push wraps", {12'h0, wa[0]}, 32'h00002);
    chk("R9", "ip push below wrap", {12'h0, wa[2]}, 32'hFFFFE);
    do_iret();
    chk("R9", "flags restored", {16'h0, flags}, 32'h3333);

    // random rounds
    for (int r = 0; r < 30; r++) begin
      ss   = 16'($urandom_range(16'h1000, 16'hEFFF));
      o_ip = 16'($urandom); o_cs = 16'($urandom); o_fl = 16'($urandom);
      o_sp = {16'($urandom_range(16'h0100, 16'hFFF0))} & 16'hFFFE;
      load_state(o_ip, o_cs, o_fl, o_sp);
      entry(8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
      do_iret();
      chk("R7", "random round ip", {16'h0, ip}, {16'h0, o_ip});
      chk("R7", "random round cs", {16'h0, cs}, {16'h0, o_cs});
      chk("R7", "random round flags", {16'h0, flags}, {16'h0, o_fl});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule